// File: doc/BRIEF.md
# Scan-Capture Clock Pulse Filter

This block sits in front of one functional clock domain during at-speed scan test and decides which edges of the free-running clock reach the domain's flops. While the scan enable input is high, the block is in shift mode and forwards every clock edge so the scan chains can load. When scan enable drops, the block enters capture mode and forwards only the launch and capture edges chosen by a programmable pattern word. After those edges it keeps the clock closed until scan enable rises again.

Scan enable arrives without any timing relation to the local clock, so it passes through two flip-flops before it is used. The synchronized level loads the pattern word into a shift register. Once capture begins, the register shifts toward its least significant end and that end drives the enable of a latch-and-AND clock gate. The latch holds the enable steady while the clock is high, so a gated pulse is never cut short. When test mode is off, the gate stays open and the clock passes through untouched.

Top module: `cpf_capture_filter`

## Requirements
- R1: With `test_mode_i` low, `gclk_o` carries every rising edge of `clk_i`, whatever `scan_en_i` and `pattern_i` do. A change of `test_mode_i` takes effect from the next rising edge.
- R2: With `test_mode_i` high and `scan_en_i` held high, `gclk_o` carries every rising edge of `clk_i`.
- R3: `scan_en_i` is synchronized by two flip-flops. If it falls between rising edges E0 and E1, then edges E1 and E2 are still forwarded, and pattern-controlled edges start at E3.
- R4: Pattern bit i (bit 0 first) decides whether edge E(3+i) is forwarded, with 1 meaning forward. The word is taken from `pattern_i` at edge E2.
- R5: After the PAT_LEN pattern edges, no edge is forwarded while `scan_en_i` stays low. When `scan_en_i` rises between edges R0 and R1, edges R1 and R2 still follow the capture sequence, and every edge from R3 onward is forwarded.
- R6: A change of `pattern_i` after edge E2 has no effect on the capture sequence in progress.
- R7: `gclk_o` is low whenever `clk_i` is low, so no gated pulse is longer than the high phase of the clock.
- R8: While `rst_ni` is low and `scan_en_i` is high, the synchronizer reads as shift mode and the pattern register is cleared. From the second reset edge onward, every rising edge is forwarded.
- R9: PAT_LEN (default 8) is the pattern register length. Any value of 4 or more is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running functional clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| scan_en_i | input | 1 | Scan enable: high for shift, low for capture; asynchronous to clk_i |
| test_mode_i | input | 1 | 1 enables filtering; 0 passes the clock through |
| pattern_i | input | PAT_LEN | Capture pulse pattern, bit 0 applied first |
| gclk_o | output | 1 | Gated clock to the domain |

## Verification
A wrong synchronizer depth moves the whole capture window by one edge or more. This shows at the very first pattern edge after a scan enable fall, at E3, and again in how many edges pass after the rise. A pattern register that loads late, shifts the wrong way, or fails to fill with zeros puts pulses on the wrong edges within PAT_LEN+3 cycles of the fall, or leaves stray pulses once the pattern has finished. A gate that misses its latch or ignores test mode either drops shift edges at once or shows a high output during the low phase of the clock. The bench samples the low phase separately so that this case is caught.

// File: rtl/cpf_pkg.sv
// Package: shared constants and types for the capture clock filter.
// Assumes: a two-flop synchronizer is enough for the scan enable input.
package cpf_pkg;

    localparam int SYNC_DEPTH  = 2;
    localparam int MIN_PAT_LEN = 4;

    typedef enum logic [1:0] {
        MODE_BYPASS  = 2'd0,
        MODE_SHIFT   = 2'd1,
        MODE_CAPTURE = 2'd2
    } cpf_mode_e;

endpackage

// File: rtl/cpf_se_sync.sv
// Module: brings the asynchronous scan enable into the clk_i domain.
// Assumes: a synchronous active-low reset; stages reset to 1 (shift mode).
module cpf_se_sync
    import cpf_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);

    logic [SYNC_DEPTH-1:0] stage_q;

    // Shift the raw level through the synchronizer chain.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            stage_q <= '1;
        end else begin
            stage_q <= {stage_q[SYNC_DEPTH-2:0], async_i};
        end
    end

    assign sync_o = stage_q[SYNC_DEPTH-1];

    // R3: a synchronized low level reflects the input two edges earlier
    a_r3_sync_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sync_o) |-> ($past(async_i, 2) == 1'b0));

endmodule

// File: rtl/cpf_pattern_sr.sv
// Module: pattern register; loads in parallel, then shifts toward bit 0.
// Assumes: load_i is synchronous to clk_i; zeros fill from the top.
module cpf_pattern_sr #(
    parameter int PAT_LEN = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               load_i,
    input  logic [PAT_LEN-1:0] pattern_i,
    output logic               bit_o
);

    logic [PAT_LEN-1:0] sr_q;
    logic [PAT_LEN-1:0] sr_d;

    // Next value for each bit: parallel load or take the bit above.
    for (genvar gi = 0; gi < PAT_LEN; gi++) begin : g_bit
        if (gi == PAT_LEN - 1) begin : g_top
            assign sr_d[gi] = load_i ? pattern_i[gi] : 1'b0;
        end else begin : g_mid
            assign sr_d[gi] = load_i ? pattern_i[gi] : sr_q[gi+1];
        end
    end

    // Register the pattern state.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign bit_o = sr_q[0];

    // R4: a load cycle captures the pattern word
    a_r4_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (sr_q == $past(pattern_i)));

    // R5: an empty register stays empty while capture continues
    a_r5_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && (sr_q == '0)) |=> (sr_q == '0));

    // R6: shifting never brings a one in from the top
    a_r6_zero_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> (sr_q[PAT_LEN-1] == 1'b0));

endmodule

// File: rtl/cpf_clk_gate.sv
// Module: glitch-free clock gate, a low-transparent latch followed by an AND.
// Assumes: en_i changes only after rising edges of clk_i.
module cpf_clk_gate (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic gclk_o
);

    logic en_lat;

    // Hold the enable through the high phase of the clock.
    always_latch begin
        if (!clk_i) begin
            en_lat = en_i;
        end
    end

    assign gclk_o = clk_i & en_lat;

    // R7: the gated clock is low just before every rising edge
    a_r7_low_before_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !gclk_o);

endmodule

// File: rtl/cpf_capture_filter.sv
// Module: top of the capture clock filter. It picks bypass, shift or
// capture mode and drives the gate enable from that mode.
// Assumes: PAT_LEN >= 4; pattern_i is held steady until two edges after
// the scan enable falls.
module cpf_capture_filter
    import cpf_pkg::*;
#(
    parameter int PAT_LEN = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               scan_en_i,
    input  logic               test_mode_i,
    input  logic [PAT_LEN-1:0] pattern_i,
    output logic               gclk_o
);

    localparam int LEN_OK = (PAT_LEN >= MIN_PAT_LEN) ? 1 : 0;

    if (LEN_OK == 0) begin : g_len_check
        $error("PAT_LEN below minimum");
    end

    logic      se_sync;
    logic      pat_bit;
    logic      gate_en;
    cpf_mode_e mode;

    cpf_se_sync u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (scan_en_i),
        .sync_o  (se_sync)
    );

    cpf_pattern_sr #(.PAT_LEN(PAT_LEN)) u_sr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (se_sync),
        .pattern_i (pattern_i),
        .bit_o     (pat_bit)
    );

    // Decode the operating mode from test mode and the synchronized enable.
    always_comb begin
        if (!test_mode_i) begin
            mode = MODE_BYPASS;
        end else if (se_sync) begin
            mode = MODE_SHIFT;
        end else begin
            mode = MODE_CAPTURE;
        end
    end

    // Open the gate fully except in capture, where the pattern decides.
    always_comb begin
        unique case (mode)
            MODE_CAPTURE: gate_en = pat_bit;
            default:      gate_en = 1'b1;
        endcase
    end

    cpf_clk_gate u_gate (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (gate_en),
        .gclk_o (gclk_o)
    );

    // R1: bypass keeps the gate open
    a_r1_bypass_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !test_mode_i |-> gate_en);

    // R2: a synchronized shift level keeps the gate open
    a_r2_shift_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
        se_sync |-> gate_en);

endmodule

// File: tb/test_cpf_capture_filter.sv
module test_cpf_capture_filter;

    localparam int LEN = 8;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           scan_en;
    logic           test_mode;
    logic [LEN-1:0] pattern;
    logic           gclk;
    int             checks = 0;
    int             fails  = 0;
    bit             done   = 1'b0;

    always #5 clk = ~clk;

    cpf_capture_filter #(.PAT_LEN(LEN)) i_cpf_capture_filter (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .scan_en_i   (scan_en),
        .test_mode_i (test_mode),
        .pattern_i   (pattern),
        .gclk_o      (gclk)
    );

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: gclk actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Wait for the next rising edge and sample the gated clock in the high phase.
    task automatic edge_chk(input logic exp, input string req);
        @(posedge clk);
        #2;
        check(gclk, exp, req);
    endtask

    // Sample during the low phase (R7).
    task automatic low_chk();
        @(negedge clk);
        #2;
        check(gclk, 1'b0, "R7");
        @(posedge clk);
        #2;
    endtask

    // Expected pulse on edge n after the fall of scan enable (R3/R4/R5).
    function automatic logic exp_cap(input logic [LEN-1:0] p, input int n);
        if (n <= 2)           return 1'b1;
        else if (n - 3 < LEN) return p[n-3];
        else                  return 1'b0;
    endfunction

    function automatic string tag_of(input int n);
        if (n <= 2)           return "R3";
        else if (n - 3 < LEN) return "R4";
        else                  return "R5";
    endfunction

    // Capture with scan enable rising after rise_after edges.
    task automatic capture(input logic [LEN-1:0] p, input int rise_after, input bit change_pat);
        pattern = p;
        scan_en = 1'b0;
        for (int n = 1; n <= rise_after; n++) begin
            edge_chk(exp_cap(p, n), change_pat ? "R6" : tag_of(n));
            if (change_pat && n == 2) pattern = ~p;
        end
        scan_en = 1'b1;
        for (int m = 1; m <= 3; m++) begin
            if (m <= 2) edge_chk(exp_cap(p, rise_after + m), "R5");
            else        edge_chk(1'b1, "R5");
        end
        pattern = p;
        edge_chk(1'b1, "R2");
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n     = 1'b0;
        scan_en   = 1'b1;
        test_mode = 1'b1;
        pattern   = '0;
        @(posedge clk);
        @(posedge clk);
        #2;
        check(gclk, 1'b1, "R8");
        edge_chk(1'b1, "R8");
        low_chk();
        rst_n = 1'b1;

        // R2: shift mode passes every edge
        for (int i = 0; i < 4; i++) edge_chk(1'b1, "R2");

        // Directed captures: R3, R4, R5, R9 (full length of PAT_LEN)
        capture(8'b0000_0101, LEN + 6, 1'b0);
        capture(8'b1111_1111, LEN + 4, 1'b0);
        capture(8'b0000_0000, LEN + 4, 1'b0);
        capture(8'b1000_0000, LEN + 5, 1'b0);
        capture(8'b0110_1001, LEN + 3, 1'b1);
        capture(8'b1111_1111, 4, 1'b0);
        capture(8'b1010_1010, 1, 1'b0);
        low_chk();

        // R1: bypass ignores scan enable and pattern
        test_mode = 1'b0;
        scan_en   = 1'b0;
        pattern   = '0;
        for (int i = 0; i < LEN + 6; i++) edge_chk(1'b1, "R1");
        scan_en = 1'b1;
        edge_chk(1'b1, "R1");
        scan_en = 1'b0;
        for (int i = 0; i < LEN + 4; i++) edge_chk(1'b1, "R1");
        low_chk();
        // R1: turning test mode on with an empty register closes the next edge
        test_mode = 1'b1;
        edge_chk(1'b0, "R1");
        edge_chk(1'b0, "R5");
        scan_en = 1'b1;
        edge_chk(1'b0, "R5");
        edge_chk(1'b0, "R5");
        edge_chk(1'b1, "R5");

        // Random captures
        for (int it = 0; it < 40; it++) begin
            logic [LEN-1:0] p;
            int             ra;
            bit             cp;
            p  = LEN'($urandom);
            ra = 1 + int'($urandom % (LEN + 6));
            cp = 1'($urandom % 2);
            capture(p, ra, cp);
            if (it % 8 == 0) low_chk();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule